// File: doc/BRIEF.md
# Addressable Byte Slave Port

This block is a byte-wide parallel port on the slave side. An external host drives it with a chip select, a read strobe, a write strobe, a small address and an 8-bit data bus. Behind the port there are four input byte buffers, which the host writes and local logic reads as one packed 32-bit word, and four output byte buffers, which local logic loads as one 32-bit word and the host reads a byte at a time. Host strobes pass through a two-flop synchronizer into the local clock domain. An access takes effect on the rising edge of the synchronized strobe, and only while chip select is high.

Three slave modes choose the buffer that a host access touches. In legacy mode every access goes to buffer 0. In buffered mode separate write and read pointers walk through buffers 0, 1, 2, 3 and then wrap. In addressable mode the host address selects the buffer. A sticky interrupt flag records host activity. In buffered and addressable modes a policy bit selects whether the flag is raised by every byte access or only by an access to buffer 3, so a whole four-byte burst can count as one event. The flag stays set until local logic clears it, and the interrupt output is the flag gated by an interrupt enable. While the module enable is low, host strobes are ignored.

Top module: `byte_slave_port`

## Requirements
- R1: Buffer n occupies bits [8n+7:8n] of in_word_o and of out_word_i. Buffer 3 is therefore bits [31:24].
- R2: In addressable mode (mode_i = 2'b10, and also 2'b11) the host address selects the buffer: a host write stores host_data_i into input buffer host_addr_i, and a host read returns output buffer host_addr_i.
- R3: In buffered mode (mode_i = 2'b01) host writes fill buffers 0, 1, 2, 3 in that order and host reads return buffers 0, 1, 2, 3 in that order, each through its own pointer. Each pointer wraps to 0 after buffer 3, and host_addr_i is ignored. The read pointer advances when the read strobe is released.
- R4: In legacy mode (mode_i = 2'b00) every host write and read uses buffer 0, whatever host_addr_i is.
- R5: In legacy mode, and in the other modes while irq_sel_i = 0, every host byte write and every host byte read sets irq_flag_o.
- R6: In buffered or addressable mode with irq_sel_i = 1, only a host access to buffer 3 sets irq_flag_o. Accesses to buffers 0 to 2 leave it clear.
- R7: irq_flag_o is sticky. It stays set until a one-cycle pulse on irq_clr_i clears it. When a new event and a clear arrive in the same cycle, the event wins.
- R8: irq_o is high exactly when irq_flag_o and irq_en_i are both high. Changing irq_en_i never changes irq_flag_o.
- R9: While en_i is low, host strobes change no buffer, no status bit and no flag.
- R10: A host write becomes visible on in_word_o after the third rising clock edge that follows the strobe assertion, and not before. A strobe while host_cs_i is low has no effect.
- R11: Bit n of in_full_o is set by a host write to buffer n and cleared by an in_rd_i pulse. Bit n of out_empty_o is set by a host read of buffer n and cleared by an out_load_i pulse, which also loads out_word_i. After reset in_full_o = 4'h0 and out_empty_o = 4'hF.
- R12: host_data_oe_o is high only while en_i, host_cs_i and host_rd_i are all high. host_data_o is 8'h00 whenever host_data_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable |
| mode_i | input | 2 | 00 legacy, 01 buffered, 10/11 addressable |
| irq_sel_i | input | 1 | 1: only a buffer 3 access raises the flag (buffered and addressable modes) |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clear pulse for the interrupt flag |
| host_cs_i | input | 1 | Host chip select, active high |
| host_rd_i | input | 1 | Host read strobe, active high |
| host_wr_i | input | 1 | Host write strobe, active high |
| host_addr_i | input | 2 | Host buffer address |
| host_data_i | input | 8 | Host write data |
| host_data_o | output | 8 | Host read data |
| host_data_oe_o | output | 1 | Output enable for the host data pads |
| in_word_o | output | 32 | Packed input buffers |
| in_rd_i | input | 1 | Local read pulse for the input word; clears in_full_o |
| out_word_i | input | 32 | Word to load into the output buffers |
| out_load_i | input | 1 | Load pulse for the output buffers; clears out_empty_o |
| in_full_o | output | 4 | One bit per input buffer: host has written it |
| out_empty_o | output | 4 | One bit per output buffer: host has read it |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the wrap of the buffered-mode pointers together with the buffer-3-only interrupt policy. The pointers cannot be seen directly, so they show only through the order of the bytes on in_word_o and host_data_o across several full bursts. The bench therefore sweeps every address in addressable mode, then performs eight writes and five reads in buffered mode with a fixed dummy address. This places each byte in a fixed, computable lane and shows the wrap to buffer 0. The three-edge synchronizer latency is checked by sampling in_word_o after the second and after the third rising edge that follow a single strobe.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int unsigned NBUF   = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_LEGACY    = 2'b00,
    MODE_BUFFERED  = 2'b01,
    MODE_ADDRESSED = 2'b10
  } port_mode_e;
endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/bsp_buffers.sv
module bsp_buffers
  import bsp_pkg::*;
#(
  parameter int unsigned NB     = NBUF,
  parameter int unsigned DW     = BYTE_W,
  localparam int unsigned IDX_W = $clog2(NB),
  localparam int unsigned WW    = NB * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             wr_evt_i,
  input  logic             rd_evt_i,
  input  logic             rd_lvl_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [DW-1:0]    host_din_i,
  output logic [DW-1:0]    host_dout_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             in_rd_i,
  input  logic [WW-1:0]    out_word_i,
  input  logic             out_load_i,
  output logic [WW-1:0]    in_word_o,
  output logic [NB-1:0]    in_full_o,
  output logic [NB-1:0]    out_empty_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  logic [IDX_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             rd_active_q;
  logic [WW-1:0]    out_w;

  always_comb begin
    case (mode_i)
      MODE_LEGACY: begin
        wr_idx_o = '0;
        rd_idx_o = '0;
      end
      MODE_BUFFERED: begin
        wr_idx_o = wr_ptr_q;
        rd_idx_o = rd_ptr_q;
      end
      default: begin
        wr_idx_o = host_addr_i;
        rd_idx_o = host_addr_i;
      end
    endcase
  end

  // pointers run only in buffered mode; the read pointer moves on strobe release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      rd_active_q <= 1'b0;
    end else if (!en_i || mode_i != MODE_BUFFERED) begin
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      rd_active_q <= 1'b0;
    end else begin
      if (wr_evt_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_evt_i) begin
        rd_active_q <= 1'b1;
      end else if (rd_active_q && !rd_lvl_i) begin
        rd_active_q <= 1'b0;
        rd_ptr_q    <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < int'(NB); b++) begin : g_buf
    logic [DW-1:0] in_q, out_q;
    logic          full_q, empty_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q   <= '0;
        full_q <= 1'b0;
      end else if (wr_evt_i && wr_idx_o == IDX_W'(b)) begin
        in_q   <= host_din_i;
        full_q <= 1'b1;
      end else if (in_rd_i) begin
        full_q <= 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q   <= '0;
        empty_q <= 1'b1;
      end else if (out_load_i) begin
        out_q   <= out_word_i[b*DW +: DW];
        empty_q <= 1'b0;
      end else if (rd_evt_i && rd_idx_o == IDX_W'(b)) begin
        empty_q <= 1'b1;
      end
    end

    assign in_word_o[b*DW +: DW] = in_q;
    assign out_w[b*DW +: DW]     = out_q;
    assign in_full_o[b]          = full_q;
    assign out_empty_o[b]        = empty_q;
  end

  assign host_dout_o = out_w[rd_idx_o*DW +: DW];

  assert_ptr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_BUFFERED && wr_evt_i && wr_ptr_q == LAST) |=> (wr_ptr_q == '0));

  assert_full_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_rd_i && !wr_evt_i) |=> (in_full_o == '0));
endmodule

// File: rtl/bsp_irq.sv
module bsp_irq
  import bsp_pkg::*;
#(
  parameter int unsigned NB     = NBUF,
  localparam int unsigned IDX_W = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             sel_last_i,
  input  logic             irq_en_i,
  input  logic             clr_i,
  input  logic             wr_evt_i,
  input  logic             rd_evt_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             flag_o,
  output logic             irq_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

  logic every_byte, evt, flag_q;

  assign every_byte = (mode_i == MODE_LEGACY) || !sel_last_i;
  assign evt = (wr_evt_i && (every_byte || wr_idx_i == LAST)) ||
               (rd_evt_i && (every_byte || rd_idx_i == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (evt)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  assert_flag_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !wr_evt_i && !rd_evt_i) |=> !flag_q);

  assert_evt_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_evt_i || rd_evt_i) && every_byte) |=> flag_q);
endmodule

// File: rtl/byte_slave_port.sv
module byte_slave_port
  import bsp_pkg::*;
#(
  parameter int unsigned NB       = NBUF,
  parameter int unsigned DW       = BYTE_W,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned IDX_W   = $clog2(NB),
  localparam int unsigned WW      = NB * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             irq_sel_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  input  logic             host_cs_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  input  logic [IDX_W-1:0] host_addr_i,
  input  logic [DW-1:0]    host_data_i,
  output logic [DW-1:0]    host_data_o,
  output logic             host_data_oe_o,
  output logic [WW-1:0]    in_word_o,
  input  logic             in_rd_i,
  input  logic [WW-1:0]    out_word_i,
  input  logic             out_load_i,
  output logic [NB-1:0]    in_full_o,
  output logic [NB-1:0]    out_empty_o,
  output logic             irq_flag_o,
  output logic             irq_o
);
  // bit 1 = read strobe, bit 0 = write strobe
  logic [1:0]       strb_lvl, strb_prev_q, strb_rise;
  logic             wr_evt, rd_evt;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [DW-1:0]    dout;

  bsp_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({host_rd_i, host_wr_i}),
    .lvl_o   (strb_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_prev_q <= '0;
    else         strb_prev_q <= strb_lvl;
  end

  assign strb_rise = strb_lvl & ~strb_prev_q;
  assign wr_evt    = strb_rise[0] & host_cs_i & en_i;
  assign rd_evt    = strb_rise[1] & host_cs_i & en_i;

  bsp_buffers #(.NB(NB), .DW(DW)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .wr_evt_i    (wr_evt),
    .rd_evt_i    (rd_evt),
    .rd_lvl_i    (strb_lvl[1]),
    .host_addr_i (host_addr_i),
    .host_din_i  (host_data_i),
    .host_dout_o (dout),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .in_rd_i     (in_rd_i),
    .out_word_i  (out_word_i),
    .out_load_i  (out_load_i),
    .in_word_o   (in_word_o),
    .in_full_o   (in_full_o),
    .out_empty_o (out_empty_o)
  );

  bsp_irq #(.NB(NB)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .sel_last_i (irq_sel_i),
    .irq_en_i   (irq_en_i),
    .clr_i      (irq_clr_i),
    .wr_evt_i   (wr_evt),
    .rd_evt_i   (rd_evt),
    .wr_idx_i   (wr_idx),
    .rd_idx_i   (rd_idx),
    .flag_o     (irq_flag_o),
    .irq_o      (irq_o)
  );

  assign host_data_oe_o = en_i & host_cs_i & host_rd_i;
  assign host_data_o    = host_data_oe_o ? dout : '0;

  assert_bus_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_cs_i && host_rd_i) |-> (!host_data_oe_o && host_data_o == '0));

  assert_disabled_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(in_word_o) && !$rose(irq_flag_o)));

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/sim_byte_slave_port.sv
module sim_byte_slave_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, sel = 1'b0, ien = 1'b0, iclr = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'b00;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        oe;
  logic [31:0] in_word;
  logic        in_rd = 1'b0;
  logic [31:0] out_word = 32'h0;
  logic        out_load = 1'b0;
  logic [3:0]  in_full, out_empty;
  logic        flag, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  byte_slave_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .irq_sel_i(sel),
    .irq_en_i(ien), .irq_clr_i(iclr), .host_cs_i(cs), .host_rd_i(rd),
    .host_wr_i(wr), .host_addr_i(addr), .host_data_i(din), .host_data_o(dout),
    .host_data_oe_o(oe), .in_word_o(in_word), .in_rd_i(in_rd),
    .out_word_i(out_word), .out_load_i(out_load), .in_full_o(in_full),
    .out_empty_o(out_empty), .irq_flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d, input logic sel_cs);
    @(negedge clk); cs = sel_cs; addr = a; din = d; wr = 1'b1;
    repeat (4) @(negedge clk); wr = 1'b0;
    repeat (4) @(negedge clk); cs = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); cs = 1'b1; addr = a; rd = 1'b1;
    @(negedge clk);
    chk({req, " read data"}, {24'h0, dout}, {24'h0, exp});
    chk("R12 oe during read", {31'h0, oe}, 32'h1);
    repeat (3) @(negedge clk); rd = 1'b0;
    repeat (4) @(negedge clk); cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_in_rd();
    @(negedge clk); in_rd = 1'b1; @(negedge clk); in_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); iclr = 1'b1; @(negedge clk); iclr = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] m, input logic s);
    @(negedge clk); en = 1'b0; mode = m; sel = s;
    @(negedge clk); en = 1'b1;
  endtask

  logic [31:0] exp_word;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R11 reset in_full", {28'h0, in_full}, 32'h0);
    chk("R11 reset out_empty", {28'h0, out_empty}, 32'hF);
    chk("R7 reset flag", {31'h0, flag}, 32'h0);
    chk("R12 reset oe", {31'h0, oe}, 32'h0);

    // load output word while disabled
    @(negedge clk); out_word = 32'h44332211; out_load = 1'b1;
    @(negedge clk); out_load = 1'b0;
    chk("R11 load clears empty", {28'h0, out_empty}, 32'h0);

    // disabled port ignores strobes
    mode = 2'b10; sel = 1'b0; ien = 1'b1;
    hwrite(2'd1, 8'h99, 1'b1);
    chk("R9 disabled write word", in_word, 32'h0);
    chk("R9 disabled write full", {28'h0, in_full}, 32'h0);
    chk("R9 disabled write flag", {31'h0, flag}, 32'h0);

    // addressable sweep, every-byte policy
    cfg(2'b10, 1'b0);
    exp_word = 32'h0;
    for (int a = 0; a < 4; a++) begin
      logic [7:0] d;
      d = 8'hA0 + 8'(17 * a);
      hwrite(2'(a), d, 1'b1);
      exp_word[a*8 +: 8] = d;
      chk("R2 R1 addressed write lane", in_word, exp_word);
      chk("R11 full bit", {28'h0, in_full}, 32'((1 << (a + 1)) - 1));
      chk("R5 flag on write", {31'h0, flag}, 32'h1);
      chk("R8 irq with enable", {31'h0, irq}, 32'h1);
      pulse_clr();
      chk("R7 clear", {31'h0, flag}, 32'h0);
    end
    for (int a = 3; a >= 0; a--) begin
      hread(2'(a), 8'(32'h44332211 >> (8 * a)), "R2 R1");
      chk("R5 flag on read", {31'h0, flag}, 32'h1);
      pulse_clr();
    end
    chk("R11 empty after reads", {28'h0, out_empty}, 32'hF);
    pulse_in_rd();
    @(negedge clk);
    chk("R11 in_rd clears full", {28'h0, in_full}, 32'h0);

    // synchronizer latency and chip select
    @(negedge clk); cs = 1'b1; addr = 2'd0; din = 8'h5A; wr = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet after two edges", in_word, 32'hD3C2B1A0);
    @(posedge clk); #1;
    chk("R10 visible after third edge", in_word, 32'hD3C2B15A);
    @(negedge clk); wr = 1'b0;
    repeat (4) @(negedge clk); cs = 1'b0;
    pulse_clr();
    hwrite(2'd1, 8'hEE, 1'b0);
    chk("R10 no cs no write", in_word, 32'hD3C2B15A);
    chk("R10 no cs no flag", {31'h0, flag}, 32'h0);

    // buffer-3-only policy
    cfg(2'b10, 1'b1);
    for (int a = 0; a < 3; a++) begin
      hwrite(2'(a), 8'(8'h10 + a), 1'b1);
      chk("R6 no flag below buffer 3", {31'h0, flag}, 32'h0);
    end
    hread(2'd1, 8'h22, "R6");
    chk("R6 no flag on read of buffer 1", {31'h0, flag}, 32'h0);
    hwrite(2'd3, 8'h13, 1'b1);
    chk("R6 flag on buffer 3", {31'h0, flag}, 32'h1);
    chk("R1 buffer 3 is top byte", in_word, 32'h13121110);
    @(negedge clk); ien = 1'b0;
    @(negedge clk);
    chk("R8 irq masked", {31'h0, irq}, 32'h0);
    chk("R8 flag kept when masked", {31'h0, flag}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", {31'h0, flag}, 32'h1);
    ien = 1'b1;
    @(negedge clk);
    chk("R8 irq back", {31'h0, irq}, 32'h1);
    pulse_clr();
    chk("R7 cleared", {31'h0, flag}, 32'h0);

    // buffered mode: sequential lanes with wrap
    cfg(2'b01, 1'b0);
    for (int n = 0; n < 8; n++) begin
      hwrite(2'd2, 8'(8'h20 + n), 1'b1);
      if (n == 3) chk("R3 first burst", in_word, 32'h23222120);
    end
    chk("R3 wrap burst", in_word, 32'h27262524);
    for (int n = 0; n < 5; n++)
      hread(2'd3, 8'(32'h44332211 >> (8 * (n % 4))), "R3");
    pulse_clr();
    cfg(2'b01, 1'b1);
    for (int n = 0; n < 3; n++) hwrite(2'd3, 8'(8'h30 + n), 1'b1);
    chk("R6 buffered no flag early", {31'h0, flag}, 32'h0);
    hwrite(2'd0, 8'h33, 1'b1);
    chk("R6 buffered flag on 4th", {31'h0, flag}, 32'h1);
    chk("R3 buffered lanes", in_word, 32'h33323130);
    pulse_clr();

    // legacy mode: buffer 0 only, every access flags
    cfg(2'b00, 1'b1);
    hwrite(2'd3, 8'hC3, 1'b1);
    chk("R4 legacy write lane 0", in_word, 32'h333231C3);
    chk("R5 legacy flag ignores sel", {31'h0, flag}, 32'h1);
    pulse_clr();
    hread(2'd2, 8'h11, "R4");
    chk("R5 legacy read flag", {31'h0, flag}, 32'h1);

    // disable and confirm strobes ignored again
    pulse_clr();
    @(negedge clk); en = 1'b0;
    hwrite(2'd0, 8'h77, 1'b1);
    chk("R9 disabled after use", in_word, 32'h333231C3);
    @(negedge clk); cs = 1'b1; rd = 1'b1;
    @(negedge clk);
    chk("R12 no drive while disabled", {23'h0, oe, dout}, 32'h0);
    rd = 1'b0; cs = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 disabled flag", {31'h0, flag}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule